// File: doc/BRIEF.md
# Arbitrary glitch waveform sequencer

This block drives the sample code of a parallel DAC whose output sets a target device's supply voltage. Software first uses a simple register-write port to load a glitch shape into an internal sample buffer. It also sets an idle supply code, a trigger delay, a playback rate and the number of samples to play. When the block is armed and the synchronized external trigger rises, the block waits the programmed number of clock ticks. It then replays the stored samples in address order, holding each sample for a programmable number of ticks, and finally drives the idle code again.

Glitch shapes are computed elsewhere and loaded as finished samples. The shape length is programmable from one sample up to the full buffer. Each glitch needs its own arm. While a glitch is pending or playing, the configuration and the buffer are frozen, so a running glitch cannot be changed partway through.

Top module: `glitch_wave_seq`

## Requirements
- R1: After reset, `dac_code` is 0 (the reset idle code), `busy` and `done` are low, the block is disarmed, the delay and rate fields are 0 and the sample count is the full buffer.
- R2: A trigger rising edge that arrives while the block is not armed starts nothing: `dac_code` stays at the idle code and `busy` stays low.
- R3: `trig_in` passes through a two-flop synchronizer. If the first rising clock edge that samples `trig_in` high is edge k and the delay field is D, then stored sample 0 is first driven after edge k+3+D.
- R4: Samples are played in increasing address order starting at address 0. With a rate field of R, each sample is held for R+1 clock cycles.
- R5: With a count field of L, playback ends after samples 0 to L. L = DEPTH-1 plays the whole 2048-entry buffer, and L = 0 plays one sample.
- R6: Whenever no sample is playing, including right after a glitch, `dac_code` equals the programmed idle code.
- R7: `busy` is high from edge k+2 until playback ends. `done` is high for exactly one cycle, and that is the first cycle after playback in which the output is back at the idle code.
- R8: Accepting a trigger clears the arm (single shot). A second trigger edge without a new `arm` pulse starts nothing.
- R9: Writes of every kind are ignored while `busy` is high. The shape buffer and all configuration fields keep their values.
- R10: Write kinds on `wr_kind` are as follows. 0 writes shape sample `wr_data[DW-1:0]` at `wr_addr`. 1 sets the idle code from `wr_data[DW-1:0]`. 2 sets the delay D. 3 sets the rate R. 4 sets the count L from `wr_data[AW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; delay and sample ticks count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write kind selector (see R10) |
| wr_addr | input | AW (11) | Shape buffer address for kind 0 |
| wr_data | input | CW (24) | Write data |
| arm | input | 1 | One-cycle pulse that arms the next trigger |
| trig_in | input | 1 | Asynchronous external trigger |
| dac_code | output | DW (12) | DAC sample code |
| busy | output | 1 | Delay or playback in progress |
| done | output | 1 | One-cycle pulse at return to idle |

## Verification
The bench builds the block with its default parameters: a 2048-entry buffer, 12-bit codes and 24-bit configuration fields. With these values, full-buffer playback and the top buffer address are tested directly, as is the one-sample shape. The randomized glitches use delays from 0 to 40, rates from 0 to 3 and lengths up to 64 samples. This covers the edges where a delay expires or a sample hold ends.

// File: rtl/glitch_wave_seq.sv
module glitch_wave_seq #(
  parameter int DEPTH = 2048,
  parameter int DW    = 12,
  parameter int CW    = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_kind,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     arm,
  input  logic                     trig_in,
  output logic [DW-1:0]            dac_code,
  output logic                     busy,
  output logic                     done
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PLAY} st_t;

  st_t             st;
  logic [DW-1:0]   shape_mem [DEPTH];
  logic [DW-1:0]   idle_code;
  logic [CW-1:0]   delay_cfg, rate_cfg, cnt;
  logic [AW-1:0]   last_idx, idx;
  logic            armed, t1, t2, t3;

  wire trig_rise = t2 & ~t3;
  wire wr_ok     = wr_en && (st == S_IDLE);
  wire accept    = (st == S_IDLE) && armed && trig_rise;

  assign busy     = (st != S_IDLE);
  assign dac_code = (st == S_PLAY) ? shape_mem[idx] : idle_code;

  always_ff @(posedge clk)
    if (wr_ok && wr_kind == 3'd0) shape_mem[wr_addr] <= wr_data[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_code <= '0;
      delay_cfg <= '0;
      rate_cfg  <= '0;
      last_idx  <= AW'(DEPTH - 1);
    end else if (wr_ok) begin
      case (wr_kind)
        3'd1: idle_code <= wr_data[DW-1:0];
        3'd2: delay_cfg <= wr_data;
        3'd3: rate_cfg  <= wr_data;
        3'd4: last_idx  <= wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {t1, t2, t3} <= '0;
      armed <= 1'b0;
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      t1   <= trig_in;
      t2   <= t1;
      t3   <= t2;
      done <= 1'b0;
      if (accept)   armed <= 1'b0;
      else if (arm) armed <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st  <= S_WAIT;
          cnt <= delay_cfg;
        end
        S_WAIT: if (cnt == '0) begin
          st  <= S_PLAY;
          idx <= '0;
          cnt <= rate_cfg;
        end else cnt <= cnt - 1'b1;
        S_PLAY: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (idx == last_idx) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            cnt <= rate_cfg;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && dac_code == idle_code));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !armed);
  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(t2) && !$past(t3)));
  // R9
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(idle_code) && $stable(rate_cfg) && $stable(last_idx)));
  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PLAY) |-> (idx <= last_idx));
endmodule

// File: tb/glitch_wave_seq_tb.sv
module glitch_wave_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;
  localparam int DW = 12;
  localparam int CW = 24;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, wr_en = 0, arm = 0, trig_in = 0;
  logic [2:0] wr_kind = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [DW-1:0] dac_code;
  logic busy, done;

  int checks = 0, errors = 0, cycles = 0;
  int model_mem [DEPTH];
  int m_idle = 0, m_delay = 0, m_rate = 0, m_last = DEPTH - 1;

  glitch_wave_seq #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_addr(wr_addr), .wr_data(wr_data), .arm(arm), .trig_in(trig_in),
    .dac_code(dac_code), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int play_end(int d, int r, int l);
    return 3 + d + (l + 1) * (r + 1);
  endfunction

  function automatic int exp_dac(int j, int d, int r, int l);
    if (j >= 3 + d && j < play_end(d, r, l)) return model_mem[(j - 3 - d) / (r + 1)];
    return m_idle;
  endfunction

  task automatic write(input int kind, input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_kind = 3'(kind); wr_addr = AW'(addr); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cfg(input int d, input int r, input int l);
    write(2, 0, d); m_delay = d;
    write(3, 0, r); m_rate = r;
    write(4, 0, l); m_last = l;
  endtask

  task automatic pulse_arm;
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic run_glitch(input bit poke);
    int e, bad_dac, bad_flag, first_a, first_e, done_cnt;
    e = play_end(m_delay, m_rate, m_last);
    bad_dac = 0; bad_flag = 0; done_cnt = 0; first_a = 0; first_e = 0;
    @(negedge clk); trig_in = 1;
    for (int j = 0; j <= e + 2; j++) begin
      @(negedge clk);
      wr_en = 0;
      if (int'(dac_code) != exp_dac(j, m_delay, m_rate, m_last)) begin
        if (bad_dac == 0) begin first_a = dac_code; first_e = exp_dac(j, m_delay, m_rate, m_last); end
        bad_dac++;
      end
      if (busy != (j >= 2 && j < e)) bad_flag++;
      if (done != (j == e)) bad_flag++;
      if (done) done_cnt++;
      if (poke && j == 4 && e >= 6) begin
        wr_en = 1; wr_kind = (cycles % 2 == 0) ? 3'd0 : 3'd1;
        wr_addr = '0; wr_data = CW'(model_mem[0] ^ 12'h5A5);
      end
    end
    wr_en = 0;
    trig_in = 0;
    check(bad_dac == 0, "R3/R4/R5/R6 glitch trace", first_a, first_e);
    check(bad_flag == 0 && done_cnt == 1, "R7 busy/done timing", bad_flag, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_quiet(input string req);
    int bad = 0;
    @(negedge clk); trig_in = 1;
    repeat (50) begin
      @(negedge clk);
      if (busy || done || int'(dac_code) != m_idle) bad++;
    end
    trig_in = 0;
    repeat (3) @(negedge clk);
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20190828));
    repeat (3) @(negedge clk);
    check(dac_code == '0, "R1 reset dac", dac_code, 0);
    check(!busy && !done, "R1 reset flags", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    // R10 fill the buffer through write kind 0
    for (int a = 0; a < DEPTH; a++) begin
      model_mem[a] = int'($urandom % 4096);
      write(0, a, model_mem[a]);
    end
    write(1, 0, 12'h7C3); m_idle = 12'h7C3;
    check(int'(dac_code) == m_idle, "R6 R10 idle code driven", dac_code, m_idle);

    // R2 trigger while disarmed
    expect_quiet("R2 unarmed trigger ignored");

    // R5 full buffer, delay 0, rate 0 (R1 defaults for count)
    pulse_arm();
    run_glitch(0);

    // R5 single-sample shape
    cfg(0, 0, 0);
    pulse_arm();
    run_glitch(0);

    // R8 no re-arm
    expect_quiet("R8 second trigger without arm");

    // R9 write during busy is ignored; next glitch must match old content
    cfg(7, 2, 9);
    pulse_arm();
    run_glitch(1);
    pulse_arm();
    run_glitch(0);

    // random glitches
    for (int n = 0; n < 30; n++) begin
      cfg(int'($urandom % 41), int'($urandom % 4), int'($urandom % 64));
      if (n % 5 == 0) begin
        m_idle = int'($urandom % 4096);
        write(1, 0, m_idle);
      end
      pulse_arm();
      run_glitch(n % 3 == 0);
    end

    // R4 long hold, R3 long delay
    cfg(40, 3, 3);
    pulse_arm();
    run_glitch(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule